// File: doc/BRIEF.md
# Multicycle Datapath Sequencing Controller

This block is the control unit of a multicycle load/store processor. It holds a 4-bit state register and moves through a fixed set of ten steps. The steps are: instruction fetch, decode with register read, memory address calculation, memory read, load write-back, memory write, ALU execute, ALU write-back, conditional branch and jump. Every datapath control line is a function of the current state alone, so the machine is a Moore machine. The 6-bit opcode held in the instruction register affects only the choice of the next state.

The datapath feeds the opcode field into the block. The block returns the write enables, the memory strobes and the multiplexer selects for that cycle. The control outputs are registered together with the state, so a new state and its control word become visible at the same clock edge. Every control line that a step does not name is driven to 0.

Top module: `mcc_ctrl_fsm`

## Requirements
- R1: A synchronous active-high `rst`, sampled at a rising edge, loads state 0 with the fetch control word. This also holds when `rst` arrives in the middle of an instruction.
- R2: State 0 drives `pc_wr`=1, `mem_rd`=1, `ir_wr`=1, `iord`=0, `alu_a_sel`=0, `alu_b_sel`=01, `alu_op`=00 and `pc_src`=00, and always moves to state 1.
- R3: State 1 drives `alu_a_sel`=0, `alu_b_sel`=11 and `alu_op`=00. Its next state depends on the opcode: 000000 goes to 6, 000010 goes to 9, 000100 goes to 8, and 100011 or 101011 goes to 2.
- R4: In state 1, any opcode other than the five listed in R3 returns the machine to state 0.
- R5: State 2 drives `alu_a_sel`=1, `alu_b_sel`=10 and `alu_op`=00. It moves to state 5 when the opcode is 101011 and to state 3 otherwise.
- R6: State 3 drives `mem_rd`=1 and `iord`=1, and moves to state 4. State 4 drives `rf_wr`=1, `mem_to_reg`=1 and `reg_dst`=0.
- R7: State 5 drives `mem_wr`=1 and `iord`=1.
- R8: State 6 drives `alu_a_sel`=1, `alu_b_sel`=00 and `alu_op`=10, and moves to state 7. State 7 drives `rf_wr`=1, `reg_dst`=1 and `mem_to_reg`=0.
- R9: State 8 drives `alu_a_sel`=1, `alu_b_sel`=00, `alu_op`=01, `pc_wr_cond`=1 and `pc_src`=01.
- R10: State 9 drives `pc_wr`=1 and `pc_src`=10.
- R11: States 4, 5, 7, 8 and 9 move to state 0. The unused state codes 10 to 15 also move to state 0, so `state` never reads above 9.
- R12: In every state, any control line that the requirement for that state does not name is 0. `mem_rd` and `mem_wr` are never high together, and `rf_wr` is high only in states 4 and 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field from the instruction register |
| state | output | 4 | Current step number |
| pc_wr | output | 1 | Unconditional program counter write |
| pc_wr_cond | output | 1 | Program counter write qualified by the ALU zero flag |
| iord | output | 1 | Memory address select: 0 = PC, 1 = ALU result register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_wr | output | 1 | Instruction register load |
| mem_to_reg | output | 1 | Write-back source: 1 = memory data, 0 = ALU result |
| pc_src | output | 2 | Next PC select: 00 ALU, 01 ALU result register, 10 jump target |
| alu_op | output | 2 | ALU operation class: 00 add, 01 subtract, 10 function field |
| alu_b_sel | output | 2 | ALU B operand: 00 reg B, 01 constant 4, 10 immediate, 11 shifted immediate |
| alu_a_sel | output | 1 | ALU A operand: 0 = PC, 1 = reg A |
| rf_wr | output | 1 | Register file write enable |
| reg_dst | output | 1 | Destination register field: 1 = rd, 0 = rt |

## Verification
The assertions check on every cycle the transitions that the current state and opcode fully decide:
- fetch always goes to decode;
- the completion states return to fetch;
- the dispatch for R-type and for unknown opcodes;
- the store/load split after the address step.

They also check on every cycle that the state stays in range, that the two memory strobes are exclusive, that register writes happen only in the two write-back steps, and that fetch emits its control word after reset.

The bench's scenarios are the only way to show the full control word of each step along each instruction class's path, in the right order. They also show that a reset arriving in the middle of an instruction aborts it to fetch.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

  localparam int ST_W = 4;
  localparam int OP_W = 6;

  // Step numbers; sequence and dispatch targets depend on these codes
  localparam logic [ST_W-1:0] ST_FETCH  = 4'd0;
  localparam logic [ST_W-1:0] ST_DECODE = 4'd1;
  localparam logic [ST_W-1:0] ST_ADDR   = 4'd2;
  localparam logic [ST_W-1:0] ST_LDMEM  = 4'd3;
  localparam logic [ST_W-1:0] ST_LDWB   = 4'd4;
  localparam logic [ST_W-1:0] ST_STMEM  = 4'd5;
  localparam logic [ST_W-1:0] ST_EXEC   = 4'd6;
  localparam logic [ST_W-1:0] ST_RWB    = 4'd7;
  localparam logic [ST_W-1:0] ST_BRANCH = 4'd8;
  localparam logic [ST_W-1:0] ST_JUMP   = 4'd9;

  // Opcode encodings
  localparam logic [OP_W-1:0] OPC_RTYPE = 6'b000000;
  localparam logic [OP_W-1:0] OPC_JMP   = 6'b000010;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OP_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OP_W-1:0] OPC_STORE = 6'b101011;

  typedef enum logic [2:0] {
    CLS_ALU,
    CLS_JUMP,
    CLS_BRANCH,
    CLS_LOAD,
    CLS_STORE,
    CLS_UNKNOWN
  } op_class_e;

  typedef struct packed {
    logic       pc_wr;
    logic       pc_wr_cond;
    logic       iord;
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_wr;
    logic       mem_to_reg;
    logic [1:0] pc_src;
    logic [1:0] alu_op;
    logic [1:0] alu_b_sel;
    logic       alu_a_sel;
    logic       rf_wr;
    logic       reg_dst;
  } ctrl_t;

endpackage

// File: rtl/mcc_op_class.sv
module mcc_op_class
  import mcc_pkg::*;
#(
  parameter int                W_OP      = OP_W,
  parameter logic [W_OP-1:0]   OP_RTYPE  = OPC_RTYPE,
  parameter logic [W_OP-1:0]   OP_JMP    = OPC_JMP,
  parameter logic [W_OP-1:0]   OP_BEQ    = OPC_BEQ,
  parameter logic [W_OP-1:0]   OP_LOAD   = OPC_LOAD,
  parameter logic [W_OP-1:0]   OP_STORE  = OPC_STORE
) (
  input  logic [W_OP-1:0] opcode,
  output op_class_e       op_class
);

  always_comb begin
    if      (opcode == OP_RTYPE) op_class = CLS_ALU;
    else if (opcode == OP_JMP)   op_class = CLS_JUMP;
    else if (opcode == OP_BEQ)   op_class = CLS_BRANCH;
    else if (opcode == OP_LOAD)  op_class = CLS_LOAD;
    else if (opcode == OP_STORE) op_class = CLS_STORE;
    else                         op_class = CLS_UNKNOWN;
  end

endmodule

// File: rtl/mcc_next_state.sv
module mcc_next_state
  import mcc_pkg::*;
#(
  parameter int W_ST = ST_W
) (
  input  logic [W_ST-1:0] cur,
  input  op_class_e       op_class,
  output logic [W_ST-1:0] nxt
);

  always_comb begin
    unique case (cur)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        unique case (op_class)
          CLS_ALU:              nxt = ST_EXEC;
          CLS_JUMP:             nxt = ST_JUMP;
          CLS_BRANCH:           nxt = ST_BRANCH;
          CLS_LOAD, CLS_STORE:  nxt = ST_ADDR;
          default:              nxt = ST_FETCH;
        endcase
      end
      ST_ADDR:   nxt = (op_class == CLS_STORE) ? ST_STMEM : ST_LDMEM;
      ST_LDMEM:  nxt = ST_LDWB;
      ST_EXEC:   nxt = ST_RWB;
      default:   nxt = ST_FETCH;  // completion steps and unused codes
    endcase
  end

endmodule

// File: rtl/mcc_decode.sv
module mcc_decode
  import mcc_pkg::*;
#(
  parameter int W_ST = ST_W
) (
  input  logic [W_ST-1:0] st,
  output ctrl_t           ctrl
);

  always_comb begin
    ctrl = '0;
    unique case (st)
      ST_FETCH: begin
        ctrl.mem_rd    = 1'b1;
        ctrl.ir_wr     = 1'b1;
        ctrl.pc_wr     = 1'b1;
        ctrl.alu_b_sel = 2'b01;
      end
      ST_DECODE: ctrl.alu_b_sel = 2'b11;
      ST_ADDR: begin
        ctrl.alu_a_sel = 1'b1;
        ctrl.alu_b_sel = 2'b10;
      end
      ST_LDMEM: begin
        ctrl.mem_rd = 1'b1;
        ctrl.iord   = 1'b1;
      end
      ST_LDWB: begin
        ctrl.rf_wr      = 1'b1;
        ctrl.mem_to_reg = 1'b1;
      end
      ST_STMEM: begin
        ctrl.mem_wr = 1'b1;
        ctrl.iord   = 1'b1;
      end
      ST_EXEC: begin
        ctrl.alu_a_sel = 1'b1;
        ctrl.alu_op    = 2'b10;
      end
      ST_RWB: begin
        ctrl.rf_wr   = 1'b1;
        ctrl.reg_dst = 1'b1;
      end
      ST_BRANCH: begin
        ctrl.alu_a_sel  = 1'b1;
        ctrl.alu_op     = 2'b01;
        ctrl.pc_wr_cond = 1'b1;
        ctrl.pc_src     = 2'b01;
      end
      ST_JUMP: begin
        ctrl.pc_wr  = 1'b1;
        ctrl.pc_src = 2'b10;
      end
      default: ctrl = '0;
    endcase
  end

endmodule

// File: rtl/mcc_ctrl_fsm.sv
module mcc_ctrl_fsm
  import mcc_pkg::*;
#(
  parameter int W_OP = OP_W,
  parameter int W_ST = ST_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [W_OP-1:0] opcode,
  output logic [W_ST-1:0] state,
  output logic            pc_wr,
  output logic            pc_wr_cond,
  output logic            iord,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            ir_wr,
  output logic            mem_to_reg,
  output logic [1:0]      pc_src,
  output logic [1:0]      alu_op,
  output logic [1:0]      alu_b_sel,
  output logic            alu_a_sel,
  output logic            rf_wr,
  output logic            reg_dst
);

  op_class_e       cls;
  logic [W_ST-1:0] st_q, st_nxt, st_load;
  ctrl_t           ctrl_nxt, ctrl_q;

  mcc_op_class #(.W_OP(W_OP)) u_class (
    .opcode   (opcode),
    .op_class (cls)
  );

  mcc_next_state #(.W_ST(W_ST)) u_next (
    .cur      (st_q),
    .op_class (cls),
    .nxt      (st_nxt)
  );

  // Reset selects the fetch step; the control word is decoded from the
  // state being loaded so both registers change on the same edge.
  assign st_load = rst ? ST_FETCH : st_nxt;

  mcc_decode #(.W_ST(W_ST)) u_dec (
    .st   (st_load),
    .ctrl (ctrl_nxt)
  );

  always_ff @(posedge clk) begin
    st_q   <= st_load;
    ctrl_q <= ctrl_nxt;
  end

  assign state      = st_q;
  assign pc_wr      = ctrl_q.pc_wr;
  assign pc_wr_cond = ctrl_q.pc_wr_cond;
  assign iord       = ctrl_q.iord;
  assign mem_rd     = ctrl_q.mem_rd;
  assign mem_wr     = ctrl_q.mem_wr;
  assign ir_wr      = ctrl_q.ir_wr;
  assign mem_to_reg = ctrl_q.mem_to_reg;
  assign pc_src     = ctrl_q.pc_src;
  assign alu_op     = ctrl_q.alu_op;
  assign alu_b_sel  = ctrl_q.alu_b_sel;
  assign alu_a_sel  = ctrl_q.alu_a_sel;
  assign rf_wr      = ctrl_q.rf_wr;
  assign reg_dst    = ctrl_q.reg_dst;

endmodule

// File: rtl/mcc_ctrl_chk.sv
module mcc_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [5:0] opcode,
  input logic [3:0] state,
  input logic       pc_wr,
  input logic       ir_wr,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       rf_wr
);

  p_reset_fetch_r1: assert property (@(posedge clk)
    rst |=> (state == 4'd0 && mem_rd && ir_wr && pc_wr));

  p_fetch_to_decode_r2: assert property (@(posedge clk) disable iff (rst)
    state == 4'd0 |=> state == 4'd1);

  p_rtype_dispatch_r3: assert property (@(posedge clk) disable iff (rst)
    (state == 4'd1 && opcode == 6'b000000) |=> state == 4'd6);

  p_unknown_op_r4: assert property (@(posedge clk) disable iff (rst)
    (state == 4'd1 && opcode != 6'b000000 && opcode != 6'b000010 &&
     opcode != 6'b000100 && opcode != 6'b100011 && opcode != 6'b101011)
    |=> state == 4'd0);

  p_store_split_r5: assert property (@(posedge clk) disable iff (rst)
    (state == 4'd2 && opcode == 6'b101011) |=> state == 4'd5);

  p_done_return_r11: assert property (@(posedge clk) disable iff (rst)
    (state == 4'd4 || state == 4'd5 || state == 4'd7 ||
     state == 4'd8 || state == 4'd9) |=> state == 4'd0);

  p_state_range_r11: assert property (@(posedge clk) disable iff (rst)
    state <= 4'd9);

  p_mem_excl_r12: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  p_rf_wr_steps_r12: assert property (@(posedge clk) disable iff (rst)
    rf_wr |-> (state == 4'd4 || state == 4'd7));

endmodule

bind mcc_ctrl_fsm mcc_ctrl_chk chk_i (
  .clk    (clk),
  .rst    (rst),
  .opcode (opcode),
  .state  (state),
  .pc_wr  (pc_wr),
  .ir_wr  (ir_wr),
  .mem_rd (mem_rd),
  .mem_wr (mem_wr),
  .rf_wr  (rf_wr)
);

// File: tb/mcc_ctrl_fsm_tb_top.sv
`timescale 1ns/1ps
module mcc_ctrl_fsm_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'b0;
  logic [3:0] state;
  logic pc_wr, pc_wr_cond, iord, mem_rd, mem_wr, ir_wr, mem_to_reg;
  logic [1:0] pc_src, alu_op, alu_b_sel;
  logic alu_a_sel, rf_wr, reg_dst;

  int checks = 0;
  int fails  = 0;
  logic [3:0] exp_q[$];

  always #2 clk = ~clk;  // 250 MHz

  mcc_ctrl_fsm dut_i (
    .clk(clk), .rst(rst), .opcode(opcode), .state(state),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .iord(iord),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr),
    .mem_to_reg(mem_to_reg), .pc_src(pc_src), .alu_op(alu_op),
    .alu_b_sel(alu_b_sel), .alu_a_sel(alu_a_sel), .rf_wr(rf_wr),
    .reg_dst(reg_dst)
  );

  function automatic logic [15:0] got_ctrl();
    return {pc_wr, pc_wr_cond, iord, mem_rd, mem_wr, ir_wr, mem_to_reg,
            pc_src, alu_op, alu_b_sel, alu_a_sel, rf_wr, reg_dst};
  endfunction

  // Expected control word per step, taken from the requirements
  function automatic logic [15:0] exp_ctrl(input logic [3:0] s);
    logic pw = 0, pwc = 0, ad = 0, rd = 0, wr = 0, ir = 0, m2r = 0;
    logic [1:0] ps = 0, op = 0, b = 0;
    logic a = 0, rw = 0, dst = 0;
    case (s)
      4'd0: begin pw = 1; rd = 1; ir = 1; b = 2'b01; end      // R2
      4'd1: b = 2'b11;                                       // R3
      4'd2: begin a = 1; b = 2'b10; end                      // R5
      4'd3: begin rd = 1; ad = 1; end                        // R6
      4'd4: begin rw = 1; m2r = 1; end                       // R6
      4'd5: begin wr = 1; ad = 1; end                        // R7
      4'd6: begin a = 1; op = 2'b10; end                     // R8
      4'd7: begin rw = 1; dst = 1; end                       // R8
      4'd8: begin a = 1; op = 2'b01; pwc = 1; ps = 2'b01; end // R9
      4'd9: begin pw = 1; ps = 2'b10; end                    // R10
      default: ;
    endcase
    return {pw, pwc, ad, rd, wr, ir, m2r, ps, op, b, a, rw, dst};
  endfunction

  function automatic string req_of(input logic [3:0] s);
    case (s)
      4'd0: return "R2/R11";
      4'd1: return "R3";
      4'd2: return "R5";
      4'd3, 4'd4: return "R6";
      4'd5: return "R7";
      4'd6, 4'd7: return "R8";
      4'd8: return "R9";
      4'd9: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check_step(input logic [3:0] s, input string req);
    checks++;
    if (state !== s || got_ctrl() !== exp_ctrl(s)) begin
      fails++;
      $display("FAIL %s: state=%0d ctrl=%h expected state=%0d ctrl=%h",
               req, state, got_ctrl(), s, exp_ctrl(s));
    end
  endtask

  // Monitor: compares each cycle's result with the scoreboard
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [3:0] s;
      s = exp_q.pop_front();
      check_step(s, req_of(s));
    end
  end

  // Driver: applies an opcode while in fetch and pushes the expected path
  task automatic run_op(input logic [5:0] op);
    logic [3:0] path[$];
    opcode = op;
    path.push_back(4'd1);
    case (op)
      6'b000000: begin path.push_back(4'd6); path.push_back(4'd7); end
      6'b000010: path.push_back(4'd9);
      6'b000100: path.push_back(4'd8);
      6'b100011: begin path.push_back(4'd2); path.push_back(4'd3); path.push_back(4'd4); end
      6'b101011: begin path.push_back(4'd2); path.push_back(4'd5); end
      default: ;  // R4: unknown opcode returns straight to fetch
    endcase
    path.push_back(4'd0);
    foreach (path[i]) exp_q.push_back(path[i]);
    repeat (path.size()) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_step(4'd0, "R1 reset");
    rst = 1'b0;
    run_op(6'b000000);  // R8 R-type
    run_op(6'b100011);  // R6 load
    run_op(6'b101011);  // R7 store
    run_op(6'b000100);  // R9 branch
    run_op(6'b000010);  // R10 jump
    run_op(6'b111111);  // R4 unknown
    run_op(6'b000001);  // R4 unknown
    run_op(6'b101011);  // R5 back-to-back
    run_op(6'b100011);
    // R1: reset in the middle of an R-type instruction
    opcode = 6'b000000;
    repeat (2) @(negedge clk);  // now in step 6
    checks++;
    if (state !== 4'd6) begin
      fails++;
      $display("FAIL R1 pre-reset: state=%0d expected=6", state);
    end
    rst = 1'b1;
    @(negedge clk);
    check_step(4'd0, "R1 mid-instruction");
    rst = 1'b0;
    run_op(6'b000010);
    run_op(6'b000000);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule